// File: doc/BRIEF.md
# Asynchronous External Memory Bus Sequencer

This block turns single-transfer requests from an on-chip requester into timed accesses on an asynchronous external memory bus of the SRAM or parallel flash kind. Each request picks a direction (read or write) and an address space (program or data). It also carries a wait-state count that stretches the strobe. The sequencer then steps through a fixed order: address and space select are placed on the bus, then the active-low read or write strobe is pulsed, then a hold interval follows with the strobe released, and last the bus returns to idle.

The bidirectional data bus is split into three signals: an output value, an output enable and an input value. The pad ring combines them. When the enable is low the pad is in high impedance. The enable is raised only while a write is being strobed or held. Read data is sampled on the last strobe cycle and returned to the requester as a one-cycle response pulse. The requester sees a ready signal that is low for the whole access and rises again only after an idle bus cycle.

All delays are counted in whole clock cycles. The address setup length and the hold length are build-time parameters. The strobe length is set per request from the wait-state input.

Top module: `xmb_bridge`

## Requirements
- R1: While the bus is idle (req_ready high), and also during reset, both strobes and both space selects are high and bus_doe is low.
- R2: An access with req_prog=1 drives bus_prog_n low and an access with req_prog=0 drives bus_data_n low, from the first setup cycle to the last hold cycle. The two selects are never low in the same cycle.
- R3: bus_addr and the space select are valid for SETUP_CYC cycles before the strobe falls. They stay unchanged through the strobe and the hold interval.
- R4: The strobe (bus_rd_n for req_write=0, bus_wr_n for req_write=1) is low for exactly 1+W consecutive cycles. W is the wait_states value sampled in the cycle the request is accepted.
- R5: bus_doe rises in the same cycle as bus_wr_n falls, never earlier. It stays high, with bus_dout unchanged, for HOLD_CYC cycles after bus_wr_n returns high.
- R6: bus_doe is low on every cycle of a read access.
- R7: bus_din is sampled on the last low cycle of bus_rd_n. That value appears on rsp_rdata while rsp_valid is high for exactly one cycle, the first cycle after bus_rd_n rises.
- R8: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is low from the next cycle until the access ends, and every access is preceded by at least one cycle with all strobes and selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_prog | input | 1 | 1 = program space, 0 = data space |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| wait_states | input | WS_W | Extra strobe cycles for this access |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | External address lines |
| bus_prog_n | output | 1 | Program-space select, active low |
| bus_data_n | output | 1 | Data-space select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DATA_W | Data value driven toward the pads |
| bus_doe | output | 1 | Data output enable; low means high impedance |
| bus_din | input | DATA_W | Data value received from the pads |

## Verification
The bench first writes the same address in both spaces with different values and then reads each one back. Any mix-up between the two selects therefore shows up as wrong data. Wait-state counts of 0, 1, 2, 3, 5, 7 and the maximum of 15 are all used, so a strobe that is one cycle short or long is caught for both directions. Writes of all-ones, all-zeros and alternating patterns are followed by reads, and untouched addresses are also read. This shows whether the write data was driven over the strobe edge and held past it, or only sampled while the strobe was still low. Requests are issued back to back, which tests the forced idle cycle between accesses.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } xmb_phase_e;

   function automatic int xmb_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/xmb_req_latch.sv
module xmb_req_latch #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int WS_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              in_write,
   input  logic              in_prog,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic [WS_W-1:0]   in_ws,
   output logic              q_write,
   output logic              q_prog,
   output logic [ADDR_W-1:0] q_addr,
   output logic [DATA_W-1:0] q_wdata,
   output logic [WS_W-1:0]   q_ws
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_write <= 1'b0;
         q_prog  <= 1'b0;
         q_addr  <= '0;
         q_wdata <= '0;
         q_ws    <= '0;
      end else if (take) begin
         q_write <= in_write;
         q_prog  <= in_prog;
         q_addr  <= in_addr;
         q_wdata <= in_wdata;
         q_ws    <= in_ws;
      end
   end

endmodule

// File: rtl/xmb_sequencer.sv
module xmb_sequencer
   import xmb_pkg::*;
#(
   parameter int WS_W      = 4,
   parameter int SETUP_CYC = 1,
   parameter int HOLD_CYC  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [WS_W-1:0] ws_val,
   output xmb_phase_e      phase,
   output logic            strobe_last
);

   localparam int FIX_MAX = xmb_max(SETUP_CYC, HOLD_CYC);
   localparam int FIX_W   = xmb_max($clog2(FIX_MAX), 1);
   localparam int CNT_W   = xmb_max(FIX_W, WS_W);
   localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             at_zero;

   assign at_zero     = (cnt == '0);
   assign strobe_last = (phase == PH_STROBE) && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_SETUP;
                  cnt   <= SETUP_LD;
               end
            end
            PH_SETUP: begin
               if (at_zero) begin
                  phase <= PH_STROBE;
                  cnt   <= CNT_W'(ws_val);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_STROBE: begin
               if (at_zero) begin
                  phase <= PH_HOLD;
                  cnt   <= HOLD_LD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               if (at_zero) begin
                  phase <= PH_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/xmb_pin_drive.sv
module xmb_pin_drive
   import xmb_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter bit PARK_ADDR = 1'b0
) (
   input  xmb_phase_e        phase,
   input  logic              q_write,
   input  logic              q_prog,
   input  logic [ADDR_W-1:0] q_addr,
   input  logic [DATA_W-1:0] q_wdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_prog_n,
   output logic              bus_data_n,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe
);

   logic busy;
   logic strobing;

   assign busy     = (phase != PH_IDLE);
   assign strobing = (phase == PH_STROBE);

   always_comb begin
      bus_prog_n = ~(busy & q_prog);
      bus_data_n = ~(busy & ~q_prog);
      bus_rd_n   = ~(strobing & ~q_write);
      bus_wr_n   = ~(strobing & q_write);
      bus_doe    = q_write & (strobing | (phase == PH_HOLD));
      bus_dout   = bus_doe ? q_wdata : '0;
   end

   generate
      if (PARK_ADDR) begin : g_park
         assign bus_addr = busy ? q_addr : '0;
      end else begin : g_keep
         assign bus_addr = q_addr;
      end
   endgenerate

endmodule

// File: rtl/xmb_rd_capture.sv
module xmb_rd_capture #(
   parameter int DATA_W     = 16,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic [DATA_W-1:0] din,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= sample;
   end

   generate
      if (RESET_DATA) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rsp_rdata <= '0;
            else if (sample) rsp_rdata <= din;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (sample) rsp_rdata <= din;
         end
      end
   endgenerate

endmodule

// File: rtl/xmb_bridge.sv
module xmb_bridge
   import xmb_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int WS_W       = 4,
   parameter int SETUP_CYC  = 1,
   parameter int HOLD_CYC   = 1,
   parameter bit PARK_ADDR  = 1'b0,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_prog,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WS_W-1:0]   wait_states,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_prog_n,
   output logic              bus_data_n,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din
);

   initial begin
      if (ADDR_W < 1 || DATA_W < 1 || WS_W < 1)
         $fatal(1, "xmb_bridge: widths must be at least 1");
      if (SETUP_CYC < 1 || HOLD_CYC < 1)
         $fatal(1, "xmb_bridge: setup and hold lengths must be at least 1");
   end

   xmb_phase_e        phase;
   logic              strobe_last;
   logic              take;
   logic              q_write;
   logic              q_prog;
   logic [ADDR_W-1:0] q_addr;
   logic [DATA_W-1:0] q_wdata;
   logic [WS_W-1:0]   q_ws;

   assign req_ready = (phase == PH_IDLE);
   assign take      = req_valid & req_ready;

   xmb_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .in_write (req_write),
      .in_prog  (req_prog),
      .in_addr  (req_addr),
      .in_wdata (req_wdata),
      .in_ws    (wait_states),
      .q_write  (q_write),
      .q_prog   (q_prog),
      .q_addr   (q_addr),
      .q_wdata  (q_wdata),
      .q_ws     (q_ws)
   );

   xmb_sequencer #(.WS_W(WS_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (take),
      .ws_val      (q_ws),
      .phase       (phase),
      .strobe_last (strobe_last)
   );

   xmb_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PARK_ADDR(PARK_ADDR)) u_pins (
      .phase      (phase),
      .q_write    (q_write),
      .q_prog     (q_prog),
      .q_addr     (q_addr),
      .q_wdata    (q_wdata),
      .bus_addr   (bus_addr),
      .bus_prog_n (bus_prog_n),
      .bus_data_n (bus_data_n),
      .bus_rd_n   (bus_rd_n),
      .bus_wr_n   (bus_wr_n),
      .bus_dout   (bus_dout),
      .bus_doe    (bus_doe)
   );

   xmb_rd_capture #(.DATA_W(DATA_W), .RESET_DATA(RESET_DATA)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (strobe_last & ~q_write),
      .din       (bus_din),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

endmodule

// File: rtl/xmb_bridge_chk.sv
module xmb_bridge_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int WS_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic              req_prog,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic [WS_W-1:0]   wait_states,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_prog_n,
   input logic              bus_data_n,
   input logic              bus_rd_n,
   input logic              bus_wr_n,
   input logic [DATA_W-1:0] bus_dout,
   input logic              bus_doe,
   input logic [DATA_W-1:0] bus_din
);

   logic [WS_W-1:0] ws_seen;
   logic [WS_W+1:0] low_run;
   logic            strobe_low;

   assign strobe_low = ~bus_rd_n | ~bus_wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_seen <= '0;
         low_run <= '0;
      end else begin
         if (req_valid && req_ready) ws_seen <= wait_states;
         if (strobe_low) low_run <= low_run + 1'b1;
         else            low_run <= '0;
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_rd_n && bus_wr_n && bus_prog_n && bus_data_n && !bus_doe));

   a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_prog_n && !bus_data_n));

   a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_low |-> ($stable(bus_addr) && !(bus_prog_n && bus_data_n)));

   a_r4_width_end: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_low && low_run != '0) |-> (int'(low_run) == int'(ws_seen) + 1));

   a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_low |-> (int'(low_run) < int'(ws_seen) + 1));

   a_r5_drive_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> bus_doe);

   a_r5_hold_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wr_n) |-> (bus_doe && $stable(bus_dout)));

   a_r6_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_doe);

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r7_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $rose(bus_rd_n));

   a_r8_idle_before: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> $past(bus_rd_n && bus_wr_n && bus_prog_n && bus_data_n));

endmodule

bind xmb_bridge xmb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u_chk (.*);

// File: tb/sim_xmb_bridge.sv
module sim_xmb_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_prog = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [3:0]  wait_states = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [15:0] bus_addr;
   logic        bus_prog_n, bus_data_n, bus_rd_n, bus_wr_n, bus_doe;
   logic [15:0] bus_dout;
   logic [15:0] bus_din;

   always #2 clk = ~clk;

   xmb_bridge u0 (.*);

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [15:0] pmem [256];
   logic [15:0] dmem [256];
   logic [15:0] pmod [256];
   logic [15:0] dmod [256];
   int          q_w[$];
   logic [15:0] q_rd[$];

   always_comb begin
      if (!bus_rd_n) bus_din = !bus_prog_n ? pmem[bus_addr[7:0]] : dmem[bus_addr[7:0]];
      else           bus_din = 16'h0BAD;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // driver: pushes expected strobe width and read data into the scoreboard
   task automatic issue(input bit w, input bit p, input logic [15:0] a,
                        input logic [15:0] d, input logic [3:0] ws);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_prog = p;
      req_addr = a; req_wdata = d; wait_states = ws;
      q_w.push_back(1 + int'(ws));
      if (w) begin
         if (p) pmod[a[7:0]] = d; else dmod[a[7:0]] = d;
      end else begin
         q_rd.push_back(p ? pmod[a[7:0]] : dmod[a[7:0]]);
      end
      @(negedge clk);
      req_valid = 1'b0;
      wait_states = 4'hF;
   endtask

   // monitor
   int          run = 0;
   logic        p_wr_n = 1'b1, p_rd_n = 1'b1, p_doe = 1'b0, p_rsp = 1'b0, p_ready = 1'b1;
   logic        p_sel_act = 1'b0, p_quiet = 1'b1;
   logic [15:0] p_addr = '0, p_dout = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(req_ready && bus_rd_n && bus_wr_n && bus_prog_n && bus_data_n && !bus_doe && !rsp_valid,
             "R1 reset state", {bus_rd_n, bus_wr_n, bus_prog_n, bus_data_n, bus_doe}, 5'b11110);
      end else begin
         logic s;
         s = !bus_rd_n || !bus_wr_n;
         if (req_ready)
            chk(bus_rd_n && bus_wr_n && bus_prog_n && bus_data_n && !bus_doe, "R1 idle quiet",
                {bus_rd_n, bus_wr_n, bus_prog_n, bus_data_n, bus_doe}, 5'b11110);
         chk(!(!bus_prog_n && !bus_data_n), "R2 one select", {bus_prog_n, bus_data_n}, 2'b01);
         if (s) begin
            if (run == 0) begin
               chk(p_sel_act && bus_addr == p_addr, "R3 setup before strobe", bus_addr, p_addr);
            end else begin
               chk(bus_addr == p_addr, "R3 address steady", bus_addr, p_addr);
            end
            run++;
            if (!bus_wr_n) chk(bus_doe, "R5 drive during write", bus_doe, 1);
            if (!bus_rd_n) chk(!bus_doe, "R6 no drive on read", bus_doe, 0);
         end else if (run > 0) begin
            int e;
            e = (q_w.size() > 0) ? q_w.pop_front() : -1;
            chk(run == e, "R4 strobe width", run, e);
            run = 0;
            if (!p_wr_n) begin
               chk(bus_doe && bus_dout == p_dout, "R5 hold after write", bus_dout, p_dout);
               if (!bus_prog_n) pmem[bus_addr[7:0]] = bus_dout;
               else             dmem[bus_addr[7:0]] = bus_dout;
            end
         end
         if (bus_doe && !p_doe) chk(!bus_wr_n, "R5 drive not before strobe", bus_wr_n, 0);
         if (rsp_valid) begin
            logic [15:0] er;
            chk(!p_rsp && !p_rd_n && bus_rd_n, "R7 pulse timing", {p_rsp, p_rd_n, bus_rd_n}, 3'b001);
            er = (q_rd.size() > 0) ? q_rd.pop_front() : 16'hxxxx;
            chk(rsp_rdata === er, "R7 read data", rsp_rdata, er);
         end
         if (!req_ready && p_ready)
            chk(p_quiet, "R8 idle cycle before access", p_quiet, 1);
      end
      p_wr_n = bus_wr_n; p_rd_n = bus_rd_n; p_doe = bus_doe; p_rsp = rsp_valid;
      p_ready = req_ready; p_addr = bus_addr; p_dout = bus_dout;
      p_sel_act = !(bus_prog_n && bus_data_n);
      p_quiet = bus_rd_n && bus_wr_n && bus_prog_n && bus_data_n;
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         pmem[i] = 16'(i * 7) ^ 16'hA500;
         dmem[i] = 16'(i * 3) ^ 16'h5A00;
         pmod[i] = pmem[i];
         dmod[i] = dmem[i];
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R2: same address, two spaces, different data
      issue(1'b1, 1'b0, 16'h0010, 16'h1234, 4'd0);
      issue(1'b1, 1'b1, 16'h0010, 16'hABCD, 4'd2);
      issue(1'b0, 1'b0, 16'h0010, 16'h0000, 4'd0);
      issue(1'b0, 1'b1, 16'h0010, 16'h0000, 4'd3);
      // R4 extremes, untouched contents
      issue(1'b0, 1'b0, 16'h0042, 16'h0000, 4'd1);
      issue(1'b0, 1'b1, 16'h00C3, 16'h0000, 4'd15);
      issue(1'b1, 1'b0, 16'h0077, 16'hFFFF, 4'd15);
      // R5 pattern writes followed by reads
      issue(1'b1, 1'b1, 16'h0020, 16'h0000, 4'd7);
      issue(1'b1, 1'b0, 16'h0021, 16'h5555, 4'd1);
      issue(1'b0, 1'b1, 16'h0020, 16'h0000, 4'd5);
      issue(1'b0, 1'b0, 16'h0021, 16'h0000, 4'd0);
      issue(1'b0, 1'b0, 16'h0077, 16'h0000, 4'd2);
      // mixed back-to-back
      for (int k = 0; k < 12; k++) begin
         issue(k[0], k[1], 16'(8'h30 + k % 4), 16'(16'h1111 * k), 4'(k % 6));
      end
      repeat (30) @(negedge clk);
      chk(q_w.size() == 0, "R4 all strobes seen", q_w.size(), 0);
      chk(q_rd.size() == 0, "R7 all reads answered", q_rd.size(), 0);
      done = 1'b1;
      finish_run();
   end

endmodule